// File: doc/BRIEF.md
# ACPI Sleep State Sequencer

This block is a clocked controller that decides the power state of a board from two active-low sleep request pins. Each request pin first goes through a counter-based deglitch filter. A falling S3 request starts a pending delay. When the delay expires, the S5 request level decides between the S3 and S5 sleep states. Direct moves between the two sleep states are refused. A wake waits until every main supply has been good for a settle window. Losing a main supply while awake forces S5 and raises an input fault.

After standby reset or shutdown is released, the block waits for a configuration window. At the end of that window it captures two board selects: whether the 5 V dual rail is kept in sleep, and the memory voltage choice. Both stay fixed until the next reset or shutdown. It then branches to a wake or to a sleep state according to the filtered request levels. Every window is a count of clock cycles, derived from a clock-frequency parameter and a duration in microseconds. Inputs are assumed to be synchronous to `clk`.

The states are HOLD_OFF, CFG_WAIT, SETTLE, ACTIVE, S3_PENDING, S3, S5 and S5_FORCED. The transitions are:

- **hold** (any state to HOLD_OFF while reset or shutdown is asserted)
- **release** (HOLD_OFF to CFG_WAIT)
- **boot** (CFG_WAIT to SETTLE, S3 or S5)
- **settled** (SETTLE to ACTIVE)
- **request** (ACTIVE or SETTLE to S3_PENDING)
- **cancel** (S3_PENDING to ACTIVE)
- **resolve** (S3_PENDING to S3 or S5)
- **supply_lost** (ACTIVE or S3_PENDING to S5_FORCED)
- **wake** (S3, S5 or S5_FORCED to SETTLE)

Top module: `acpi_sleep_seq`

## Requirements
- R1: While `stby_por` or `shutdown` is high, the state becomes HOLD_OFF at the next edge. In HOLD_OFF all enables are low, the latched selects read 0, and all timers and filters are cleared. The first edge with both low moves to CFG_WAIT.
- R2: A request pin's filtered level changes only after the raw level has differed from it for DG consecutive cycles. A shorter pulse has no effect on the state. Filters reset to high (no request).
- R3: A filtered S3 request in ACTIVE or SETTLE enters S3_PENDING. If the request is still present after S3D cycles there, the state becomes S3 when the filtered S5 level is high, or S5 when it is low. If the request is withdrawn first, the state returns to ACTIVE.
- R4: S3 and S5 are left only when both filtered levels are high. A change of only one pin never moves S3 to S5 or S5 to S3. In ACTIVE, an S5 request with S3 high is ignored.
- R5: SETTLE moves to ACTIVE only after all `main_good` bits have been high for SET consecutive cycles. Any low bit restarts the count.
- R6: Any low `main_good` bit in ACTIVE or S3_PENDING moves to S5_FORCED at the next edge, and `in_fault` is high in that state.
- R7: S5_FORCED is left only to SETTLE, when all `main_good` bits are high, or to HOLD_OFF through R1. Sleep request pins have no effect in S5_FORCED.
- R8: `en_clk` and `en_pass` are high only in ACTIVE and S3_PENDING.
- R9: `en_dual` is high in ACTIVE and S3_PENDING. In SETTLE, S3, S5 and S5_FORCED it equals the latched dual select. It is low otherwise.
- R10: `dual_sel` and `mem_sel` are captured on the last cycle of CFG_WAIT, which lasts LAT cycles. After that, changes on the select inputs have no effect on `dual_lat` and `mem_lat` until R1 applies.
- R11: At the end of CFG_WAIT the state becomes SETTLE if both filtered levels are high, S5 if filtered S5 is low, and S3 otherwise.
- R12: `pstate` encodes HOLD_OFF=0, CFG_WAIT=1, SETTLE=2, ACTIVE=3, S3_PENDING=4, S3=5, S5=6, S5_FORCED=7. `en_stby` is high in every state except HOLD_OFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stby_por | input | 1 | Standby power-on reset, high holds the block off |
| shutdown | input | 1 | Shutdown request, high holds the block off |
| slp3_n | input | 1 | Active-low S3 sleep request |
| slp5_n | input | 1 | Active-low S5 sleep request |
| main_good | input | N_MAIN | Per-rail main supply good bits |
| dual_sel | input | 1 | Keep the 5 V dual rail in sleep (captured) |
| mem_sel | input | 1 | Memory voltage select (captured) |
| pstate | output | 3 | Current state code |
| en_stby | output | 1 | Standby rail enable |
| en_clk | output | 1 | Clock rail enable |
| en_pass | output | 1 | Pass-switch drive enable |
| en_dual | output | 1 | 5 V dual rail enable |
| in_fault | output | 1 | Input supply fault flag |
| dual_lat | output | 1 | Captured dual select |
| mem_lat | output | 1 | Captured memory select |

## Verification
The hardest case to reach is a settle window that is broken part-way through. The bench drops one main supply bit for two cycles in the middle of SETTLE. It then waits past the point where an unbroken window would have ended, to show that the count restarted. Refused sleep-to-sleep moves are reached by first resolving a pending S3 into each sleep state, then moving only one request pin. The captured selects are tested by a shutdown followed by a boot straight into S5 with the selects low, and then by raising the selects.

// File: rtl/sleep_seq_pkg.sv
package sleep_seq_pkg;

    typedef enum logic [2:0] {
        SQ_OFF       = 3'd0,
        SQ_WAIT      = 3'd1,
        SQ_SETTLE    = 3'd2,
        SQ_ACTIVE    = 3'd3,
        SQ_S3_PEND   = 3'd4,
        SQ_S3        = 3'd5,
        SQ_S5        = 3'd6,
        SQ_S5_FORCED = 3'd7
    } seq_state_e;

    // Convert a duration to clock cycles, never below one cycle.
    function automatic int us_to_cycles(input int mhz, input int us);
        return (mhz * us < 1) ? 1 : mhz * us;
    endfunction

endpackage

// File: rtl/seq_pin_filter.sv
module seq_pin_filter #(
    parameter int DG_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic raw,
    output logic filt
);
    localparam int CW = $clog2(DG_CYC + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            filt <= 1'b1;
            cnt  <= '0;
        end else if (clr) begin
            filt <= 1'b1;
            cnt  <= '0;
        end else if (raw == filt) begin
            cnt  <= '0;
        end else if (cnt == CW'(DG_CYC - 1)) begin
            filt <= raw;
            cnt  <= '0;
        end else begin
            cnt  <= cnt + 1'b1;
        end
    end

    // R2: an agreeing raw level never moves the filtered output
    assert_filter_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (raw == filt && !clr) |=> $stable(filt));

endmodule

// File: rtl/seq_span_timer.sv
module seq_span_timer #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    assign done = run && (cnt == CW'(LIMIT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt <= '0;
        else if (!run)   cnt <= '0;
        else if (done)   cnt <= '0;
        else             cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/acpi_sleep_seq.sv
module acpi_sleep_seq
    import sleep_seq_pkg::*;
#(
    parameter int CLK_MHZ     = 1,
    parameter int N_MAIN      = 3,
    parameter int DEGLITCH_US = 2,
    parameter int S3_DELAY_US = 200,
    parameter int LATCH_US    = 3000,
    parameter int SETTLE_US   = 25000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stby_por,
    input  logic              shutdown,
    input  logic              slp3_n,
    input  logic              slp5_n,
    input  logic [N_MAIN-1:0] main_good,
    input  logic              dual_sel,
    input  logic              mem_sel,
    output logic [2:0]        pstate,
    output logic              en_stby,
    output logic              en_clk,
    output logic              en_pass,
    output logic              en_dual,
    output logic              in_fault,
    output logic              dual_lat,
    output logic              mem_lat
);
    localparam int DG_CYC  = us_to_cycles(CLK_MHZ, DEGLITCH_US);
    localparam int S3D_CYC = us_to_cycles(CLK_MHZ, S3_DELAY_US);
    localparam int LAT_CYC = us_to_cycles(CLK_MHZ, LATCH_US);
    localparam int SET_CYC = us_to_cycles(CLK_MHZ, SETTLE_US);
    localparam int N_PINS  = 2;

    seq_state_e state, state_nx;
    logic       hold;
    logic       all_good;
    logic [N_PINS-1:0] pin_raw, pin_filt;
    logic       f3, f5;
    logic       lat_done, set_done, s3d_done;
    logic       dual_q, mem_q;

    assign hold     = stby_por | shutdown;
    assign all_good = &main_good;
    assign pin_raw  = {slp5_n, slp3_n};

    // Request pin deglitch filters (index 0: S3, index 1: S5)
    for (genvar g = 0; g < N_PINS; g++) begin : g_pin
        seq_pin_filter #(.DG_CYC(DG_CYC)) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (hold),
            .raw   (pin_raw[g]),
            .filt  (pin_filt[g])
        );
    end

    assign f3 = pin_filt[0];
    assign f5 = pin_filt[1];

    seq_span_timer #(.LIMIT(LAT_CYC)) u_lat_tmr (
        .clk (clk), .rst_n (rst_n),
        .run (!hold && state == SQ_WAIT),
        .done(lat_done)
    );

    seq_span_timer #(.LIMIT(SET_CYC)) u_set_tmr (
        .clk (clk), .rst_n (rst_n),
        .run (!hold && state == SQ_SETTLE && all_good),
        .done(set_done)
    );

    seq_span_timer #(.LIMIT(S3D_CYC)) u_s3d_tmr (
        .clk (clk), .rst_n (rst_n),
        .run (!hold && state == SQ_S3_PEND),
        .done(s3d_done)
    );

    // Next-state decision
    always_comb begin
        state_nx = state;
        if (hold) begin
            state_nx = SQ_OFF;
        end else begin
            unique case (state)
                SQ_OFF:     state_nx = SQ_WAIT;
                SQ_WAIT: begin
                    if (lat_done) begin
                        if (f3 && f5)  state_nx = SQ_SETTLE;
                        else if (!f5)  state_nx = SQ_S5;
                        else           state_nx = SQ_S3;
                    end
                end
                SQ_SETTLE: begin
                    if (!f3)           state_nx = SQ_S3_PEND;
                    else if (set_done) state_nx = SQ_ACTIVE;
                end
                SQ_ACTIVE: begin
                    if (!all_good)     state_nx = SQ_S5_FORCED;
                    else if (!f3)      state_nx = SQ_S3_PEND;
                end
                SQ_S3_PEND: begin
                    if (!all_good)     state_nx = SQ_S5_FORCED;
                    else if (f3)       state_nx = SQ_ACTIVE;
                    else if (s3d_done) state_nx = f5 ? SQ_S3 : SQ_S5;
                end
                SQ_S3, SQ_S5: begin
                    if (f3 && f5)      state_nx = SQ_SETTLE;
                end
                SQ_S5_FORCED: begin
                    if (all_good)      state_nx = SQ_SETTLE;
                end
                default:               state_nx = SQ_OFF;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SQ_OFF;
        else        state <= state_nx;
    end

    // Configuration capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dual_q <= 1'b0;
            mem_q  <= 1'b0;
        end else if (hold) begin
            dual_q <= 1'b0;
            mem_q  <= 1'b0;
        end else if (state == SQ_WAIT && lat_done) begin
            dual_q <= dual_sel;
            mem_q  <= mem_sel;
        end
    end

    // Outputs
    always_comb begin
        en_stby  = 1'b1;
        en_clk   = 1'b0;
        en_pass  = 1'b0;
        en_dual  = 1'b0;
        in_fault = 1'b0;
        unique case (state)
            SQ_OFF:              en_stby = 1'b0;
            SQ_WAIT:             ;
            SQ_ACTIVE, SQ_S3_PEND: begin
                en_clk  = 1'b1;
                en_pass = 1'b1;
                en_dual = 1'b1;
            end
            SQ_SETTLE, SQ_S3, SQ_S5: en_dual = dual_q;
            SQ_S5_FORCED: begin
                en_dual  = dual_q;
                in_fault = 1'b1;
            end
            default:             en_stby = 1'b0;
        endcase
    end

    assign pstate   = state;
    assign dual_lat = dual_q;
    assign mem_lat  = mem_q;

    // R1: a held reset or shutdown forces the off state
    assert_hold_to_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (state == SQ_OFF));

    // R4: sleep states never hop to each other
    assert_no_s3_to_s5_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_S3) |=> (state != SQ_S5 && state != SQ_S3_PEND));
    assert_no_s5_to_s3_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_S5) |=> (state != SQ_S3 && state != SQ_S3_PEND));

    // R5: entry into ACTIVE only from a settle window or a cancelled request
    assert_active_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_ACTIVE && $past(state) != SQ_ACTIVE)
        |-> ($past(state) == SQ_SETTLE || $past(state) == SQ_S3_PEND));

    // R6: supply loss while awake forces S5
    assert_loss_forces_s5_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && !all_good && (state == SQ_ACTIVE || state == SQ_S3_PEND))
        |=> (state == SQ_S5_FORCED));

    // R7: forced S5 stays while supplies are missing
    assert_forced_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && !all_good && state == SQ_S5_FORCED) |=> (state == SQ_S5_FORCED));

    // R10: captured selects stay fixed once configured
    assert_sel_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && state != SQ_OFF && state != SQ_WAIT)
        |=> ($stable(dual_q) && $stable(mem_q)));

endmodule

// File: tb/acpi_sleep_seq_bench.sv
module acpi_sleep_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DG  = 4;
    localparam int S3D = 40;
    localparam int LAT = 60;
    localparam int SET = 400;

    logic       clk = 1'b0;
    logic       rst_n, stby_por, shutdown, slp3_n, slp5_n, dual_sel, mem_sel;
    logic [2:0] main_good;
    logic [2:0] pstate;
    logic       en_stby, en_clk, en_pass, en_dual, in_fault, dual_lat, mem_lat;

    acpi_sleep_seq #(
        .CLK_MHZ(1), .N_MAIN(3), .DEGLITCH_US(DG), .S3_DELAY_US(S3D),
        .LATCH_US(LAT), .SETTLE_US(SET)
    ) u_acpi_sleep_seq (
        .clk(clk), .rst_n(rst_n), .stby_por(stby_por), .shutdown(shutdown),
        .slp3_n(slp3_n), .slp5_n(slp5_n), .main_good(main_good),
        .dual_sel(dual_sel), .mem_sel(mem_sel), .pstate(pstate),
        .en_stby(en_stby), .en_clk(en_clk), .en_pass(en_pass), .en_dual(en_dual),
        .in_fault(in_fault), .dual_lat(dual_lat), .mem_lat(mem_lat)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit ended = 0;

    // Behavioural reference model
    int m_st = 0, m_t = 0, m_c3 = 0, m_c5 = 0;
    bit m_f3 = 1, m_f5 = 1, m_dual = 0, m_mem = 0;

    always @(posedge clk) begin
        int nst;
        bit ag;
        if (!rst_n || stby_por || shutdown) begin
            m_st = 0; m_t = 0; m_c3 = 0; m_c5 = 0;
            m_f3 = 1; m_f5 = 1; m_dual = 0; m_mem = 0;
        end else begin
            ag  = (main_good == 3'b111);
            nst = m_st;
            case (m_st)
                0: nst = 1;
                1: if (m_t == LAT-1) begin
                       m_dual = dual_sel; m_mem = mem_sel;
                       nst = (m_f3 && m_f5) ? 2 : (!m_f5 ? 6 : 5);
                   end else m_t++;
                2: if (!m_f3) nst = 4;
                   else if (!ag) m_t = 0;
                   else if (m_t == SET-1) nst = 3;
                   else m_t++;
                3: if (!ag) nst = 7; else if (!m_f3) nst = 4;
                4: if (!ag) nst = 7;
                   else if (m_f3) nst = 3;
                   else if (m_t == S3D-1) nst = m_f5 ? 5 : 6;
                   else m_t++;
                5, 6: if (m_f3 && m_f5) nst = 2;
                default: if (ag) nst = 2;
            endcase
            if (nst != m_st) m_t = 0;
            m_st = nst;
            if (slp3_n == m_f3) m_c3 = 0;
            else if (m_c3 == DG-1) begin m_f3 = slp3_n; m_c3 = 0; end
            else m_c3++;
            if (slp5_n == m_f5) m_c5 = 0;
            else if (m_c5 == DG-1) begin m_f5 = slp5_n; m_c5 = 0; end
            else m_c5++;
        end
    end

    function automatic string tag_of(int s);
        case (s)
            0, 1:    return "R1";
            2:       return "R5";
            3:       return "R8";
            4:       return "R3";
            5, 6:    return "R4";
            default: return "R6";
        endcase
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        bit awake;
        int exp_vec, act_vec;
        if (rst_n && !ended) begin
            awake   = (m_st == 3 || m_st == 4);
            exp_vec = {m_st[2:0], m_st != 0, awake, awake,
                       awake || (m_dual && (m_st == 2 || m_st >= 5)),
                       m_st == 7, m_dual, m_mem};
            act_vec = {pstate, en_stby, en_clk, en_pass, en_dual, in_fault, dual_lat, mem_lat};
            chk(act_vec == exp_vec, {tag_of(m_st), " R12 per-cycle"}, act_vec, exp_vec);
        end
    end

    task automatic finish_run();
        ended = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !ended) begin
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
            finish_run();
        end
    end

    task automatic wt(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_for(int s, int lim);
        for (int i = 0; i < lim && pstate != 3'(s); i++) @(negedge clk);
    endtask

    initial begin
        rst_n = 0; stby_por = 1; shutdown = 0; slp3_n = 1; slp5_n = 1;
        main_good = 3'b111; dual_sel = 1; mem_sel = 1;
        wt(3); rst_n = 1; wt(3);
        chk(pstate == 0 && en_stby == 0, "R1 held off", pstate, 0);
        stby_por = 0; wt(2);
        chk(pstate == 1, "R1 release to wait", pstate, 1);
        wait_for(2, 200);
        chk(pstate == 2, "R11 boot to settle", pstate, 2);
        chk(dual_lat && mem_lat, "R10 captured selects", {dual_lat, mem_lat}, 3);
        chk(en_clk == 0, "R5 clock off while settling", en_clk, 0);
        wait_for(3, 1000);
        chk(pstate == 3, "R5 settled active", pstate, 3);
        chk(en_clk && en_pass, "R8 awake enables", {en_clk, en_pass}, 3);
        slp5_n = 0; wt(20);
        chk(pstate == 3, "R4 lone S5 ignored in active", pstate, 3);
        slp5_n = 1; wt(10);
        slp3_n = 0; wt(DG-1); slp3_n = 1; wt(10);
        chk(pstate == 3, "R2 short pulse ignored", pstate, 3);
        slp3_n = 0; wt(10);
        chk(pstate == 4, "R3 pending", pstate, 4);
        chk(en_clk == 1, "R8 clock on while pending", en_clk, 1);
        wait_for(5, 200);
        chk(pstate == 5, "R3 resolve to S3", pstate, 5);
        chk(!en_clk && !en_pass && en_dual, "R9 sleep enables",
            {en_clk, en_pass, en_dual}, 1);
        slp5_n = 0; wt(20);
        chk(pstate == 5, "R4 S3 stays with S5 low", pstate, 5);
        slp3_n = 1; slp5_n = 1;
        wait_for(3, 1000);
        chk(pstate == 3, "R5 wake from S3", pstate, 3);
        slp3_n = 0; wt(10); slp5_n = 0;
        wait_for(6, 200);
        chk(pstate == 6, "R3 resolve to S5", pstate, 6);
        slp3_n = 1; wt(20);
        chk(pstate == 6, "R4 S5 stays with S3 high", pstate, 6);
        slp5_n = 1;
        wait_for(2, 50);
        wt(200); main_good = 3'b101; wt(2); main_good = 3'b111; wt(250);
        chk(pstate == 2, "R5 window restarted", pstate, 2);
        wait_for(3, 500);
        chk(pstate == 3, "R5 active after restart", pstate, 3);
        main_good = 3'b110; wt(2);
        chk(pstate == 7 && in_fault, "R6 forced S5", {pstate, in_fault}, 15);
        slp3_n = 0; slp5_n = 0; wt(20); slp3_n = 1; slp5_n = 1; wt(20);
        chk(pstate == 7, "R7 pins ignored in forced", pstate, 7);
        main_good = 3'b111; wt(2);
        chk(pstate == 2, "R7 supply return", pstate, 2);
        wait_for(3, 500);
        main_good = 3'b011; wt(3);
        chk(pstate == 7, "R6 second loss", pstate, 7);
        shutdown = 1; wt(2);
        chk(pstate == 0 && en_stby == 0, "R1 shutdown", pstate, 0);
        dual_sel = 0; mem_sel = 0; slp3_n = 0; slp5_n = 0; main_good = 3'b111;
        shutdown = 0; wt(2);
        chk(pstate == 1, "R1 wait after shutdown", pstate, 1);
        wait_for(6, 200);
        chk(pstate == 6, "R11 boot into S5", pstate, 6);
        chk(!dual_lat && !mem_lat, "R10 captured zero", {dual_lat, mem_lat}, 0);
        chk(en_dual == 0, "R9 dual off in sleep", en_dual, 0);
        dual_sel = 1; mem_sel = 1; wt(20);
        chk(!dual_lat && !mem_lat && !en_dual, "R10 selects frozen",
            {dual_lat, mem_lat, en_dual}, 0);
        wt(5);
        finish_run();
    end

endmodule